// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

This block is a 32-line general purpose I/O bank controlled through a small word-wide register port. Software sets a per-line direction, output value, blink enable and input inversion, and reads back a synchronised, inversion-adjusted view of the pads. The pad inputs pass through a two-flop synchroniser. The adjusted view then feeds two interrupt sources. One is a level source that follows the view directly. The other is an edge source that latches a rising transition of the view until software clears it.

Each line combines its level term and its edge term, each gated by its own mask. The combined terms are ORed in groups of eight consecutive lines, which gives four interrupt outputs. A second processor can be given its own pair of mask registers and its own four grouped outputs. A shared divider makes any output line with blink enabled toggle, and all blinking lines toggle in phase.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is asserted and immediately after it, the direction register (offset 0x04) reads all ones and every other register reads zero. pin_oe is all zero, and both interrupt buses are zero.
- R2: Bit i of the direction register at 0x04 set to 1 makes line i an input (pin_oe[i]=0). Set to 0, it makes line i an output (pin_oe[i]=1). pin_out carries the output data register at 0x00 for lines that are not blinking.
- R3: Offset 0x10 reads the pad value from two clock edges earlier XORed with the inversion register at 0x0C. Writes to 0x10 are ignored.
- R4: Edge cause bit i (offset 0x14) is set one edge after the inversion-adjusted view of line i goes from 0 to 1.
- R5: A write to 0x14 clears each bit written as 0 and keeps each bit written as 1. A new edge arriving in the same cycle as a clearing write leaves the bit set.
- R6: The level term of line i is the adjusted view ANDed with the level mask at 0x1C. It is not latched and drops as soon as the view drops.
- R7: The edge term of line i is edge cause bit i ANDed with the edge mask at 0x18. It stays active after the pad returns low, until cleared.
- R8: irq_cpu0[g] is the OR of the combined level and edge terms of lines 8g to 8g+7.
- R9: The second processor's edge mask at 0x30 and level mask at 0x34 drive irq_cpu1 by the same rule as R8. They have no effect on irq_cpu0.
- R10: Where the blink enable bit at 0x08 is set, pin_out[i] is the output data bit XORed with a shared phase. The phase starts at 0 after reset and inverts every BLINK_DIV clock cycles.
- R11: Reads at unmapped offsets return zero, and writes to them change nothing. reg_rdata is zero while reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Byte offset of the register being accessed |
| reg_wr | input | 1 | Write strobe, one word per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| pin_in | input | 32 | Raw pad input values |
| pin_out | output | 32 | Value driven onto the pads |
| pin_oe | output | 32 | Pad output enable, 1 means drive |
| irq_cpu0 | output | 4 | Grouped interrupts for processor 0 |
| irq_cpu1 | output | 4 | Grouped interrupts for processor 1 |

## Verification
The hardest case to reach from the ports is an edge that lands in the same cycle as a clearing write to the cause register. The edge appears three clock edges after a pad change, because of the two synchroniser stages and the edge detector, so the bench changes the pad and then issues the write exactly one edge later. A cycle-accurate reference model also runs beside the design under a long pseudo-random mix of pad changes, inversion flips and register writes. That mix produces many more accidental collisions of this kind, along with edges caused by changing the inversion register rather than the pad.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned REG_AW = 6;

  typedef enum logic [REG_AW-1:0] {
    OFS_DOUT   = 6'h00,
    OFS_DIR    = 6'h04,
    OFS_BLINK  = 6'h08,
    OFS_INV    = 6'h0C,
    OFS_VIEW   = 6'h10,
    OFS_CAUSE  = 6'h14,
    OFS_EMASK0 = 6'h18,
    OFS_LMASK0 = 6'h1C,
    OFS_EMASK1 = 6'h30,
    OFS_LMASK1 = 6'h34
  } gpio_ofs_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_edge_cause.sv
module gpio_edge_cause #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] view,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] rise,
  output logic [W-1:0] cause
);
  logic [W-1:0] view_d;

  // bits written as 0 drop, bits written as 1 hold; a fresh edge always sets
  function automatic logic [W-1:0] next_cause(input logic [W-1:0] cur,
                                              input logic [W-1:0] keep,
                                              input logic [W-1:0] edges);
    return (cur & keep) | edges;
  endfunction

  assign rise = view & ~view_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      view_d <= '0;
      cause  <= '0;
    end else begin
      view_d <= view;
      cause  <= next_cause(cause, clr_wr ? clr_data : '1, rise);
    end
  end
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic phase
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int W  = 32,
  parameter int GW = 8
) (
  input  logic [W-1:0]    view,
  input  logic [W-1:0]    lvl_mask,
  input  logic [W-1:0]    cause,
  input  logic [W-1:0]    edge_mask,
  output logic [W/GW-1:0] irq
);
  localparam int NG = W / GW;

  function automatic logic [W-1:0] line_req(input logic [W-1:0] v,
                                            input logic [W-1:0] lm,
                                            input logic [W-1:0] c,
                                            input logic [W-1:0] em);
    return (v & lm) | (c & em);
  endfunction

  logic [W-1:0] req;
  assign req = line_req(view, lvl_mask, cause, edge_mask);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign irq[g] = |req[g*GW +: GW];
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int          NUM_LINES = 32,
  parameter int          GROUP_W   = 8,
  parameter int unsigned BLINK_DIV = 1000000,
  parameter bit          CPU1_EN   = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [REG_AW-1:0]            reg_addr,
  input  logic                         reg_wr,
  input  logic [NUM_LINES-1:0]         reg_wdata,
  input  logic                         reg_rd,
  output logic [NUM_LINES-1:0]         reg_rdata,
  input  logic [NUM_LINES-1:0]         pin_in,
  output logic [NUM_LINES-1:0]         pin_out,
  output logic [NUM_LINES-1:0]         pin_oe,
  output logic [NUM_LINES/GROUP_W-1:0] irq_cpu0,
  output logic [NUM_LINES/GROUP_W-1:0] irq_cpu1
);
  localparam int NUM_GROUPS = NUM_LINES / GROUP_W;

  logic [NUM_LINES-1:0] dout_q, dir_q, blink_q, inv_q;
  logic [NUM_LINES-1:0] emask0_q, lmask0_q, emask1_q, lmask1_q;
  logic [NUM_LINES-1:0] sync_q, data_view, edge_rise, cause_q;
  logic                 cause_wr, blink_tick, blink_phase;

  // ---------------- input path ----------------
  gpio_sync #(.W(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_q)
  );

  assign data_view = sync_q ^ inv_q;
  assign cause_wr  = reg_wr && (reg_addr == OFS_CAUSE);

  gpio_edge_cause #(.W(NUM_LINES)) u_cause (
    .clk(clk), .rst_n(rst_n), .view(data_view),
    .clr_wr(cause_wr), .clr_data(reg_wdata),
    .rise(edge_rise), .cause(cause_q)
  );

  // ---------------- register writes ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q   <= '0;
      dir_q    <= '1;
      blink_q  <= '0;
      inv_q    <= '0;
      emask0_q <= '0;
      lmask0_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_DOUT:   dout_q   <= reg_wdata;
        OFS_DIR:    dir_q    <= reg_wdata;
        OFS_BLINK:  blink_q  <= reg_wdata;
        OFS_INV:    inv_q    <= reg_wdata;
        OFS_EMASK0: emask0_q <= reg_wdata;
        OFS_LMASK0: lmask0_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  // ---------------- processor 0 interrupts ----------------
  gpio_irq_group #(.W(NUM_LINES), .GW(GROUP_W)) u_grp0 (
    .view(data_view), .lvl_mask(lmask0_q), .cause(cause_q),
    .edge_mask(emask0_q), .irq(irq_cpu0)
  );

  // ---------------- optional processor 1 masks ----------------
  if (CPU1_EN) begin : g_cpu1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        emask1_q <= '0;
        lmask1_q <= '0;
      end else if (reg_wr && reg_addr == OFS_EMASK1) begin
        emask1_q <= reg_wdata;
      end else if (reg_wr && reg_addr == OFS_LMASK1) begin
        lmask1_q <= reg_wdata;
      end
    end

    gpio_irq_group #(.W(NUM_LINES), .GW(GROUP_W)) u_grp1 (
      .view(data_view), .lvl_mask(lmask1_q), .cause(cause_q),
      .edge_mask(emask1_q), .irq(irq_cpu1)
    );
  end else begin : g_no_cpu1
    assign emask1_q = '0;
    assign lmask1_q = '0;
    assign irq_cpu1 = '0;
  end

  // ---------------- blink and pad drive ----------------
  gpio_blink_gen #(.DIV(BLINK_DIV)) u_blink (
    .clk(clk), .rst_n(rst_n), .tick(blink_tick), .phase(blink_phase)
  );

  assign pin_out = dout_q ^ (blink_q & {NUM_LINES{blink_phase}});
  assign pin_oe  = ~dir_q;

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_DOUT:   reg_rdata = dout_q;
        OFS_DIR:    reg_rdata = dir_q;
        OFS_BLINK:  reg_rdata = blink_q;
        OFS_INV:    reg_rdata = inv_q;
        OFS_VIEW:   reg_rdata = data_view;
        OFS_CAUSE:  reg_rdata = cause_q;
        OFS_EMASK0: reg_rdata = emask0_q;
        OFS_LMASK0: reg_rdata = lmask0_q;
        OFS_EMASK1: reg_rdata = emask1_q;
        OFS_LMASK1: reg_rdata = lmask1_q;
        default:    reg_rdata = '0;
      endcase
    end
  end

  if (NUM_GROUPS * GROUP_W != NUM_LINES) begin : g_bad_group
    initial $error("NUM_LINES must be a multiple of GROUP_W");
  end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int W  = 32,
  parameter int NG = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  pin_in,
  input logic [W-1:0]  sync_q,
  input logic [W-1:0]  dir_q,
  input logic [W-1:0]  cause_q,
  input logic [W-1:0]  edge_rise,
  input logic          cause_wr,
  input logic [W-1:0]  reg_wdata,
  input logic [W-1:0]  data_view,
  input logic [W-1:0]  lmask0_q,
  input logic [NG-1:0] irq_cpu0,
  input logic          blink_tick,
  input logic          blink_phase
);
  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (dir_q == '1 && cause_q == '0));

  assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (sync_q == $past(pin_in, 2)));

  assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_rise != '0) |=> ((cause_q & $past(edge_rise)) == $past(edge_rise)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr |=> ((cause_q & ~$past(reg_wdata) & ~$past(edge_rise)) == '0));

  assert_level_reaches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_view & lmask0_q) != '0) |-> (irq_cpu0 != '0));

  assert_blink_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !blink_tick |=> $stable(blink_phase));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(NUM_LINES), .NG(NUM_LINES/GROUP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync_q(sync_q), .dir_q(dir_q),
  .cause_q(cause_q), .edge_rise(edge_rise), .cause_wr(cause_wr),
  .reg_wdata(reg_wdata), .data_view(data_view), .lmask0_q(lmask0_q),
  .irq_cpu0(irq_cpu0), .blink_tick(blink_tick), .blink_phase(blink_phase)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int DIV = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b1;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, pin_in = '0;
  logic [31:0] reg_rdata, pin_out, pin_oe;
  logic [3:0]  irq_cpu0, irq_cpu1;

  gpio_irq_bank #(.NUM_LINES(32), .GROUP_W(8), .BLINK_DIV(DIV), .CPU1_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1)
  );

  int checks = 0, fails = 0;
  bit live = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_out, m_dir, m_blk, m_inv, m_cause, m_em0, m_lm0, m_em1, m_lm1;
  logic [31:0] m_s2, m_prev;
  logic [31:0] hist[$];
  int          m_cnt;
  bit          m_phase;

  task automatic m_reset();
    m_out = '0; m_dir = '1; m_blk = '0; m_inv = '0; m_cause = '0;
    m_em0 = '0; m_lm0 = '0; m_em1 = '0; m_lm1 = '0;
    m_s2 = '0; m_prev = '0; m_cnt = 0; m_phase = 0;
    hist.delete();
  endtask

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_out;
      6'h04: return m_dir;
      6'h08: return m_blk;
      6'h0C: return m_inv;
      6'h10: return m_s2 ^ m_inv;
      6'h14: return m_cause;
      6'h18: return m_em0;
      6'h1C: return m_lm0;
      6'h30: return m_em1;
      6'h34: return m_lm1;
      default: return '0;
    endcase
  endfunction

  function automatic string rtag(input logic [5:0] a);
    case (a)
      6'h00, 6'h04: return "R2 readback";
      6'h08: return "R10 readback";
      6'h0C, 6'h10: return "R3 view";
      6'h14: return "R4/R5 cause";
      6'h18: return "R7 mask";
      6'h1C: return "R6 mask";
      6'h30, 6'h34: return "R9 mask";
      default: return "R11 unmapped";
    endcase
  endfunction

  function automatic logic [3:0] m_irq(input logic [31:0] lm, input logic [31:0] em);
    logic [31:0] v;
    logic [3:0]  r;
    v = m_s2 ^ m_inv;
    r = '0;
    for (int i = 0; i < 32; i++)
      if ((v[i] & lm[i]) | (m_cause[i] & em[i])) r[i/8] = 1'b1;
    return r;
  endfunction

  initial m_reset();

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      logic [31:0] v, rise, keep;
      v = m_s2 ^ m_inv;
      rise = v & ~m_prev;
      m_prev = v;
      keep = (reg_wr && reg_addr == 6'h14) ? reg_wdata : 32'hFFFF_FFFF;
      m_cause = (m_cause & keep) | rise;
      if (reg_wr)
        case (reg_addr)
          6'h00: m_out = reg_wdata;
          6'h04: m_dir = reg_wdata;
          6'h08: m_blk = reg_wdata;
          6'h0C: m_inv = reg_wdata;
          6'h18: m_em0 = reg_wdata;
          6'h1C: m_lm0 = reg_wdata;
          6'h30: m_em1 = reg_wdata;
          6'h34: m_lm1 = reg_wdata;
          default: ;
        endcase
      if (m_cnt == DIV - 1) begin m_cnt = 0; m_phase = ~m_phase; end
      else m_cnt++;
      hist.push_front(pin_in);
      if (hist.size() > 2) void'(hist.pop_back());
      m_s2 = (hist.size() == 2) ? hist[1] : '0;
    end
  end

  // per-cycle comparison, well away from the clock edge
  always @(posedge clk) begin
    #15;
    if (live && rst_n) begin
      check("R2 pin_oe", pin_oe, ~m_dir);
      check("R2/R10 pin_out", pin_out, m_out ^ (m_blk & {32{m_phase}}));
      check("R6/R7/R8 irq_cpu0", {28'd0, irq_cpu0}, {28'd0, m_irq(m_lm0, m_em0)});
      check("R9 irq_cpu1", {28'd0, irq_cpu1}, {28'd0, m_irq(m_lm1, m_em1)});
      check(rtag(reg_addr), reg_rdata, reg_rd ? m_read(reg_addr) : 32'd0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #5;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #5;
    reg_wr = 1'b0;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(posedge clk); #5 pin_in = v;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #15;
  endtask

  task automatic peek(input logic [5:0] a);
    @(posedge clk); #5;
    reg_rd = 1'b1; reg_addr = a;
    #10;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] lfsr;
    int          flips;
    logic        last;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    live = 1;

    peek(6'h04); check("R1 direction reset", reg_rdata, 32'hFFFF_FFFF);
    check("R1 pin_oe reset", pin_oe, 32'h0);
    check("R1 irq reset", {24'd0, irq_cpu1, irq_cpu0}, 32'h0);
    peek(6'h14); check("R1 cause reset", reg_rdata, 32'h0);

    wr(6'h04, 32'hFFFF_0000);
    wr(6'h00, 32'h0000_A5A5);
    #1;
    check("R2 low half driven", pin_oe, 32'h0000_FFFF);
    check("R2 output data", pin_out, 32'h0000_A5A5);

    wr(6'h10, 32'hDEAD_BEEF);
    peek(6'h10); check("R3 view write ignored", reg_rdata, 32'h0);
    wr(6'h20, 32'hFFFF_FFFF);
    peek(6'h20); check("R11 unmapped read", reg_rdata, 32'h0);
    check("R11 unmapped write no effect", pin_out, 32'h0000_A5A5);
    #1 reg_rd = 1'b0; #1;
    check("R11 read strobe low", reg_rdata, 32'h0);

    // edge and clearing write land on the same clock edge
    set_pins(32'h0000_0008);
    @(posedge clk);
    wr(6'h14, 32'h0);
    peek(6'h14); check("R5 new edge beats clear", reg_rdata & 32'h8, 32'h8);
    wr(6'h14, 32'hFFFF_FFF7);
    peek(6'h14); check("R5 zero bit clears", reg_rdata, 32'h0);

    // level path, unlatched
    wr(6'h1C, 32'h0000_0100);
    set_pins(32'h0000_0100);
    settle(3); check("R6 level raises group 1", {28'd0, irq_cpu0}, 32'h2);
    set_pins(32'h0);
    settle(3); check("R6 level not latched", {28'd0, irq_cpu0}, 32'h0);

    // second processor masks
    wr(6'h34, 32'h0100_0000);
    set_pins(32'h0100_0000);
    settle(3);
    check("R9 cpu1 level group 3", {28'd0, irq_cpu1}, 32'h8);
    check("R9 cpu0 unaffected", {28'd0, irq_cpu0}, 32'h0);

    // edge path, latched
    wr(6'h18, 32'h0001_0000);
    set_pins(32'h0001_0000);
    settle(4);
    set_pins(32'h0);
    settle(3); check("R7 edge held after pad drops", {28'd0, irq_cpu0}, 32'h4);
    peek(6'h14); check("R4 cause bit 16", reg_rdata & 32'h0001_0000, 32'h0001_0000);
    wr(6'h14, 32'h0);
    settle(1); check("R7 edge cleared", {28'd0, irq_cpu0}, 32'h0);

    // inversion
    wr(6'h0C, 32'h0000_0001);
    peek(6'h10); check("R3 inverted view", reg_rdata & 32'h1, 32'h1);

    // blink on line 0, steady line 1
    wr(6'h08, 32'h0000_0001);
    @(posedge clk); #15;
    flips = 0; last = pin_out[0];
    for (int k = 0; k < 4 * DIV; k++) begin
      @(posedge clk); #15;
      if (pin_out[0] != last) flips++;
      last = pin_out[0];
      check("R10 non-blinking line steady", {31'd0, pin_out[1]}, 32'h0);
    end
    check("R10 toggle count", flips, 32'd4);

    // pseudo-random mix compared against the model every cycle
    lfsr = 32'h1D2C_3B4A;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0, 3'd1, 3'd2: set_pins(lfsr ^ {lfsr[15:0], lfsr[31:16]});
        3'd3: wr(6'h14, lfsr);
        3'd4: wr(6'h0C, lfsr & 32'h0F0F_F0F0);
        3'd5: wr({lfsr[5:4], 4'h0} | 6'h08, {lfsr[7:0], lfsr[31:8]});
        3'd6: wr(lfsr[8] ? 6'h30 : 6'h34, lfsr);
        default: peek({lfsr[11:8], 2'b00});
      endcase
    end
    settle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule